// File: doc/BRIEF.md
# Bus Cycle Command Generator

This block sits between a processor's multiplexed status/data bus and a system bus. At the start of every machine cycle the processor places a status byte on its data bus and pulses an active-low strobe. The block captures that byte, classifies the cycle, and then issues one active-low command (memory read, memory write, I/O read or I/O write) for the body of that cycle. A small phase machine tracks where the cycle stands, stretching the command window for as long as the ready input holds the cycle in wait states.

It also moves data in both directions. In read cycles it passes system-bus data back to the processor. In write cycles it registers the processor's write data at the end of the second state and drives that data onto the system bus. In an interrupt-acknowledge cycle it ignores the system bus and returns a fixed restart opcode (all ones by default) to the processor in the third state. A bus-enable input, active low, can switch off the command drivers and both data drivers. Tri-state drive is shown here as separate output-enable signals.

Phases: IDLE (after reset), T2 (entered on the clock edge that samples the strobe low), TW (wait), T3, and TAIL (any states after T3 until the next strobe). The transitions are as follows. A strobe sampled low moves any phase to T2. T2 goes to T3 if ready is high and to TW if it is low. TW stays in TW while ready is low and goes to T3 when ready is high. T3 goes to TAIL. TAIL stays in TAIL.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After reset all four commands are high, both data output enables are low, and cmd_oe equals the inverse of busen_n.
- R2: The status byte is taken from cpu_din at each clock edge where stb_n is low. It is held unchanged until the next such edge, so changes on cpu_din later in the cycle do not change the command.
- R3: Status bit 7 set (memory read, with bits 0, 3, 4 and 6 clear) drives memr_n low in T2, in every TW and in T3. In those phases cpu_doe is high and cpu_dout follows sys_din.
- R4: Status bit 6 set (input) drives ior_n low in the same phases as R3 and keeps memr_n high. Exactly one read command is active at a time, and the priority is halt, interrupt acknowledge, output, input, memory read.
- R5: Status bit 4 set (output) drives iow_n low from the start of T2 whatever the level of wr_n. iow_n stays low after T3 for as long as wr_n stays low.
- R6: In a write cycle (bit 4 set, or bit 1 clear) sys_dout carries the cpu_din value present at the clock edge that leaves T2. sys_doe is high in TW and T3, and after T3 while wr_n is low. Later changes on cpu_din are ignored.
- R7: Bit 1 clear with bit 4 clear (memory write) drives memw_n low exactly while wr_n is low during the cycle.
- R8: Status bit 0 set (interrupt acknowledge) issues no command. It drives cpu_dout to 0xFF with cpu_doe high in T3 only, whatever the value of sys_din.
- R9: Status bit 3 set (halt acknowledge) issues no command and enables no data driver, even when bit 7 is also set.
- R10: While busen_n is high, cmd_oe, cpu_doe and sys_doe are all low in the same cycle.
- R11: Each clock edge in T2 or TW that samples ready low adds one TW phase before T3.
- R12: In TAIL no read command is active and cpu_doe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stb_n | input | 1 | Status strobe, active low |
| ready | input | 1 | High to end wait states |
| wr_n | input | 1 | Processor write output, active low |
| busen_n | input | 1 | Bus enable, active low |
| cpu_din | input | 8 | Processor data bus (status, then write data) |
| sys_din | input | 8 | System data bus, read side |
| cpu_dout | output | 8 | Data returned to the processor |
| cpu_doe | output | 1 | Enable for cpu_dout |
| sys_dout | output | 8 | Write data to the system bus |
| sys_doe | output | 1 | Enable for sys_dout |
| memr_n | output | 1 | Memory read command |
| memw_n | output | 1 | Memory write command |
| ior_n | output | 1 | I/O read command |
| iow_n | output | 1 | I/O write command |
| cmd_oe | output | 1 | Enable for all four commands |

## Verification
Two pairs of functions can land in the same cycle. The first is bus disable with an active read. busen_n is raised during the T2 of a memory-read cycle, and the bench checks that memr_n stays low internally while cmd_oe and cpu_doe drop in that same cycle. The second is a wait extension with a write-data change. cpu_din is inverted during TW and T3 of every write vector, and the bench checks that sys_dout still shows the value captured when T2 ended while the command remains asserted.

// File: rtl/bc_pkg.sv
package bc_pkg;

    // Status byte bit positions (the decode depends on these)
    localparam int SB_INTA = 0;
    localparam int SB_WO_N = 1;
    localparam int SB_STACK = 2;
    localparam int SB_HLTA = 3;
    localparam int SB_OUT = 4;
    localparam int SB_M1 = 5;
    localparam int SB_INP = 6;
    localparam int SB_MEMR = 7;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_T2,
        PH_TW,
        PH_T3,
        PH_TAIL
    } phase_e;

    typedef enum logic [2:0] {
        CY_NONE,
        CY_MEMRD,
        CY_MEMWR,
        CY_IORD,
        CY_IOWR,
        CY_INTA,
        CY_HALT
    } cyc_e;

endpackage

// File: rtl/bc_status_latch.sv
module bc_status_latch #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] status_q
);
    import bc_pkg::*;

    // Reset value marks a read-type idle status so no write decodes
    localparam logic [DW-1:0] RST_STATUS = DW'(1) << SB_WO_N;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= RST_STATUS;
        end else if (!stb_n) begin
            status_q <= din;
        end
    end

endmodule

// File: rtl/bc_phase_fsm.sv
module bc_phase_fsm (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           stb_n,
    input  logic           ready,
    output bc_pkg::phase_e phase
);
    import bc_pkg::*;

    phase_e cur_q, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= PH_IDLE;
        end else begin
            cur_q <= nxt;
        end
    end

    always_comb begin
        nxt = cur_q;
        if (!stb_n) begin
            nxt = PH_T2;
        end else begin
            unique case (cur_q)
                PH_IDLE: nxt = PH_IDLE;
                PH_T2:   nxt = ready ? PH_T3 : PH_TW;
                PH_TW:   nxt = ready ? PH_T3 : PH_TW;
                PH_T3:   nxt = PH_TAIL;
                PH_TAIL: nxt = PH_TAIL;
                default: nxt = PH_IDLE;
            endcase
        end
    end

    assign phase = cur_q;

    // R11: a low ready held in a wait keeps the cycle waiting
    a_r11_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TW && !ready && stb_n) |=> (phase == PH_TW));

    // R11: low ready in T2 inserts a wait state
    a_r11_wait_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T2 && !ready && stb_n) |=> (phase == PH_TW));

endmodule

// File: rtl/bc_cmd_decode.sv
module bc_cmd_decode #(
    parameter int DW = 8
) (
    input  logic [DW-1:0]  status,
    input  bc_pkg::phase_e phase,
    input  logic           wr_n,
    input  logic           busen_n,
    output bc_pkg::cyc_e   kind,
    output logic           memr_n,
    output logic           memw_n,
    output logic           ior_n,
    output logic           iow_n,
    output logic           cmd_oe
);
    import bc_pkg::*;

    logic rd_win;
    logic tail_wr;

    // Cycle class from the status byte, highest priority first
    always_comb begin
        if (status[SB_HLTA]) begin
            kind = CY_HALT;
        end else if (status[SB_INTA]) begin
            kind = CY_INTA;
        end else if (status[SB_OUT]) begin
            kind = CY_IOWR;
        end else if (status[SB_INP]) begin
            kind = CY_IORD;
        end else if (status[SB_MEMR]) begin
            kind = CY_MEMRD;
        end else if (!status[SB_WO_N]) begin
            kind = CY_MEMWR;
        end else begin
            kind = CY_NONE;
        end
    end

    always_comb begin
        unique case (phase)
            PH_T2, PH_TW, PH_T3: rd_win = 1'b1;
            default:             rd_win = 1'b0;
        endcase
    end

    assign tail_wr = (phase == PH_TAIL) && !wr_n;

    always_comb begin
        memr_n = 1'b1;
        memw_n = 1'b1;
        ior_n  = 1'b1;
        iow_n  = 1'b1;
        unique case (kind)
            CY_MEMRD: memr_n = !rd_win;
            CY_IORD:  ior_n  = !rd_win;
            CY_IOWR:  iow_n  = !(rd_win || tail_wr);
            CY_MEMWR: memw_n = !((phase != PH_IDLE) && !wr_n);
            default: begin
                memr_n = 1'b1;
            end
        endcase
    end

    assign cmd_oe = !busen_n;

endmodule

// File: rtl/bc_data_steer.sv
module bc_data_steer #(
    parameter int            DW  = 8,
    parameter logic [DW-1:0] OPC = '1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  bc_pkg::cyc_e   kind,
    input  bc_pkg::phase_e phase,
    input  logic           wr_n,
    input  logic           busen_n,
    input  logic [DW-1:0]  cpu_din,
    input  logic [DW-1:0]  sys_din,
    output logic [DW-1:0]  cpu_dout,
    output logic           cpu_doe,
    output logic [DW-1:0]  sys_dout,
    output logic           sys_doe
);
    import bc_pkg::*;

    logic [DW-1:0] wdata_q;
    logic          is_rd;
    logic          is_wr;
    logic          rd_win;
    logic          wr_win;

    // Write data is taken on the edge that leaves T2
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (phase == PH_T2) begin
            wdata_q <= cpu_din;
        end
    end

    assign is_rd = (kind == CY_MEMRD) || (kind == CY_IORD);
    assign is_wr = (kind == CY_MEMWR) || (kind == CY_IOWR);

    always_comb begin
        rd_win = 1'b0;
        wr_win = 1'b0;
        unique case (phase)
            PH_T2:        rd_win = 1'b1;
            PH_TW, PH_T3: begin
                rd_win = 1'b1;
                wr_win = 1'b1;
            end
            PH_TAIL:      wr_win = !wr_n;
            default:      rd_win = 1'b0;
        endcase
    end

    assign cpu_dout = (kind == CY_INTA) ? OPC : sys_din;
    assign cpu_doe  = !busen_n &&
                      ((is_rd && rd_win) || (kind == CY_INTA && phase == PH_T3));
    assign sys_dout = wdata_q;
    assign sys_doe  = !busen_n && is_wr && wr_win;

    // R6: driven write data does not move once captured
    a_r6_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_doe && $past(phase) != PH_T2) |-> $stable(sys_dout));

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl #(
    parameter int            DW  = 8,
    parameter logic [DW-1:0] OPC = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb_n,
    input  logic          ready,
    input  logic          wr_n,
    input  logic          busen_n,
    input  logic [DW-1:0] cpu_din,
    input  logic [DW-1:0] sys_din,
    output logic [DW-1:0] cpu_dout,
    output logic          cpu_doe,
    output logic [DW-1:0] sys_dout,
    output logic          sys_doe,
    output logic          memr_n,
    output logic          memw_n,
    output logic          ior_n,
    output logic          iow_n,
    output logic          cmd_oe
);
    import bc_pkg::*;

    logic [DW-1:0] status_q;
    phase_e        phase;
    cyc_e          kind;

    bc_status_latch #(.DW(DW)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_n    (stb_n),
        .din      (cpu_din),
        .status_q (status_q)
    );

    bc_phase_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .stb_n (stb_n),
        .ready (ready),
        .phase (phase)
    );

    bc_cmd_decode #(.DW(DW)) u_dec (
        .status  (status_q),
        .phase   (phase),
        .wr_n    (wr_n),
        .busen_n (busen_n),
        .kind    (kind),
        .memr_n  (memr_n),
        .memw_n  (memw_n),
        .ior_n   (ior_n),
        .iow_n   (iow_n),
        .cmd_oe  (cmd_oe)
    );

    bc_data_steer #(.DW(DW), .OPC(OPC)) u_steer (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .phase    (phase),
        .wr_n     (wr_n),
        .busen_n  (busen_n),
        .cpu_din  (cpu_din),
        .sys_din  (sys_din),
        .cpu_dout (cpu_dout),
        .cpu_doe  (cpu_doe),
        .sys_dout (sys_dout),
        .sys_doe  (sys_doe)
    );

    // R2: cycle class holds between strobes
    a_r2_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_n && phase != PH_IDLE) |=> $stable(kind));

    // R4: never two read commands together
    a_r4_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        !(!memr_n && !ior_n));

    // R3: memory read command present in T3
    a_r3_memr_t3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T3 && kind == CY_MEMRD) |-> !memr_n);

    // R8: interrupt acknowledge issues no command
    a_r8_inta_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CY_INTA) |-> (memr_n && memw_n && ior_n && iow_n && !sys_doe));

    // R9: halt acknowledge issues nothing
    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CY_HALT) |-> (memr_n && memw_n && ior_n && iow_n && !cpu_doe && !sys_doe));

    // R10: bus disable removes every driver
    a_r10_busen_off: assert property (@(posedge clk) disable iff (!rst_n)
        busen_n |-> (!cmd_oe && !cpu_doe && !sys_doe));

    // R12: nothing read after T3
    a_r12_tail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TAIL) |-> (memr_n && ior_n && !cpu_doe));

endmodule

// File: tb/bus_cycle_ctrl_bench.sv
module bus_cycle_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stb_n = 1'b1;
    logic       ready = 1'b1;
    logic       wr_n = 1'b1;
    logic       busen_n = 1'b0;
    logic [7:0] cpu_din = 8'h00;
    logic [7:0] sys_din = 8'h00;
    logic [7:0] cpu_dout, sys_dout;
    logic       cpu_doe, sys_doe, memr_n, memw_n, ior_n, iow_n, cmd_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bus_cycle_ctrl u_bus_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .stb_n(stb_n), .ready(ready), .wr_n(wr_n),
        .busen_n(busen_n), .cpu_din(cpu_din), .sys_din(sys_din),
        .cpu_dout(cpu_dout), .cpu_doe(cpu_doe), .sys_dout(sys_dout),
        .sys_doe(sys_doe), .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n),
        .iow_n(iow_n), .cmd_oe(cmd_oe)
    );

    // Vectors: status byte, wait count, read data, write data
    localparam int NV = 9;
    localparam logic [7:0] V_ST [NV] = '{8'h82, 8'hA2, 8'h42, 8'h10, 8'h00,
                                         8'h04, 8'h23, 8'h8A, 8'h42};
    localparam int         V_WT [NV] = '{0, 2, 1, 0, 3, 1, 1, 0, 0};
    localparam logic [7:0] V_RD [NV] = '{8'h3C, 8'h5A, 8'hC3, 8'h11, 8'h22,
                                         8'h33, 8'h44, 8'h55, 8'h0F};
    localparam logic [7:0] V_WD [NV] = '{8'h01, 8'h02, 8'h03, 8'hA5, 8'h96,
                                         8'h7E, 8'h08, 8'h09, 8'h0A};

    // Cycle classes computed from the status bits
    localparam int K_NONE = 0, K_MR = 1, K_MW = 2, K_IR = 3, K_IW = 4,
                   K_INTA = 5, K_HALT = 6;

    function automatic int cls(input logic [7:0] s);
        if (s[3]) return K_HALT;
        if (s[0]) return K_INTA;
        if (s[4]) return K_IW;
        if (s[6]) return K_IR;
        if (s[7]) return K_MR;
        if (!s[1]) return K_MW;
        return K_NONE;
    endfunction

    function automatic string req_of(input int k);
        case (k)
            K_MR:   return "R3";
            K_IR:   return "R4";
            K_IW:   return "R5";
            K_MW:   return "R7";
            K_INTA: return "R8";
            K_HALT: return "R9";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // p: 0 T2, 1 TW, 2 T3, 3 after T3
    task automatic check_phase(input int k, input int p, input logic [7:0] rd,
                               input logic [7:0] wd, input string req);
        logic win, e_cpu_oe, e_sys_oe;
        win = (p < 3);
        e_cpu_oe = !busen_n && ((((k == K_MR) || (k == K_IR)) && win) ||
                                ((k == K_INTA) && p == 2));
        e_sys_oe = !busen_n && ((k == K_IW) || (k == K_MW)) &&
                   (p == 1 || p == 2 || (p == 3 && !wr_n));
        chk(req, "memr_n", {7'd0, memr_n}, {7'd0, !((k == K_MR) && win)});
        chk(req, "ior_n",  {7'd0, ior_n},  {7'd0, !((k == K_IR) && win)});
        chk(req, "iow_n",  {7'd0, iow_n},  {7'd0, !((k == K_IW) && (win || !wr_n))});
        chk(req, "memw_n", {7'd0, memw_n}, {7'd0, !((k == K_MW) && !wr_n)});
        chk(req, "cpu_doe", {7'd0, cpu_doe}, {7'd0, e_cpu_oe});
        chk(req, "sys_doe", {7'd0, sys_doe}, {7'd0, e_sys_oe});
        if (e_cpu_oe) chk(req, "cpu_dout", cpu_dout, (k == K_INTA) ? 8'hFF : rd);
        if (e_sys_oe) chk("R6", "sys_dout", sys_dout, wd);
    endtask

    task automatic run_cycle(input logic [7:0] st, input int waits,
                             input logic [7:0] rd, input logic [7:0] wd,
                             input bit hold_wr);
        int k;
        string rq;
        k = cls(st);
        rq = req_of(k);
        @(negedge clk);
        stb_n = 1'b0; cpu_din = st; ready = (waits == 0); wr_n = 1'b1;
        @(negedge clk);
        // T2: write data on the bus, write strobe low for write classes
        stb_n = 1'b1; cpu_din = wd; sys_din = rd;
        wr_n = !((k == K_IW) || (k == K_MW));
        if (k == K_IW) wr_n = 1'b1;   // R5: advanced write needs no wr_n
        #1 check_phase(k, 0, rd, wd, rq);
        if (k == K_IW) wr_n = 1'b0;
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            cpu_din = ~wd;             // R6/R2: later bus changes ignored
            ready = (i == waits - 1);
            #1 check_phase(k, 1, rd, wd, (i == 0) ? "R11" : rq);
        end
        @(negedge clk);
        cpu_din = ~wd;
        #1 check_phase(k, 2, rd, wd, rq);
        @(negedge clk);
        ready = 1'b1;
        if (!hold_wr) wr_n = 1'b1;
        #1 check_phase(k, 3, rd, wd, "R12");
        if (hold_wr) begin
            chk("R5", "iow_n held", {7'd0, iow_n}, 8'd0);
            @(negedge clk);
            wr_n = 1'b1;
            #1 chk("R5", "iow_n released", {7'd0, iow_n}, 8'd1);
        end
    endtask

    initial begin
        #5;
        // R1: reset state
        chk("R1", "memr_n", {7'd0, memr_n}, 8'd1);
        chk("R1", "memw_n", {7'd0, memw_n}, 8'd1);
        chk("R1", "ior_n",  {7'd0, ior_n},  8'd1);
        chk("R1", "iow_n",  {7'd0, iow_n},  8'd1);
        chk("R1", "doe", {6'd0, cpu_doe, sys_doe}, 8'd0);
        chk("R1", "cmd_oe", {7'd0, cmd_oe}, 8'd1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R1", "idle cmds", {4'd0, memr_n, memw_n, ior_n, iow_n}, 8'h0F);

        for (int v = 0; v < NV; v++) begin
            run_cycle(V_ST[v], V_WT[v], V_RD[v], V_WD[v], 1'b0);
        end

        // R5: write extended after T3 by a held wr_n
        run_cycle(8'h10, 1, 8'h00, 8'hC6, 1'b1);

        // R10: bus disable during an active memory read
        @(negedge clk);
        stb_n = 1'b0; cpu_din = 8'h82; ready = 1'b0;
        @(negedge clk);
        stb_n = 1'b1; sys_din = 8'h77; busen_n = 1'b1;
        #1;
        chk("R10", "cmd_oe", {7'd0, cmd_oe}, 8'd0);
        chk("R10", "cpu_doe", {7'd0, cpu_doe}, 8'd0);
        chk("R10", "memr_n internal", {7'd0, memr_n}, 8'd0);
        @(negedge clk);
        busen_n = 1'b0; ready = 1'b1;
        #1 chk("R10", "cpu_doe back", {7'd0, cpu_doe}, 8'd1);
        chk("R11", "still waiting", {7'd0, memr_n}, 8'd0);

        // R10: bus disable in a write cycle
        @(negedge clk);
        @(negedge clk);
        stb_n = 1'b0; cpu_din = 8'h00; ready = 1'b1;
        @(negedge clk);
        stb_n = 1'b1; cpu_din = 8'h5F; wr_n = 1'b0;
        @(negedge clk);
        busen_n = 1'b1;
        #1 chk("R10", "sys_doe", {7'd0, sys_doe}, 8'd0);
        busen_n = 1'b0;
        #1 chk("R6", "sys_dout", sys_dout, 8'h5F);
        @(negedge clk);
        wr_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule